// File: doc/BRIEF.md
# UART Interrupt Source Prioritizer

This block gathers the four interrupt causes of a classic PC-style serial port and presents the most urgent one to software through a read-only identification byte. The four causes are receiver line errors, received data ready, transmit holding register empty, and modem status change. Each cause is latched when its event pulse arrives. It stays latched until software makes the access that services it. A read of the line-status or modem-status register, a read or write of the data register, or in one case a read of the identification byte itself, clears the matching cause. The block also reports that clear back to the logic that raised the cause, as a one-cycle pulse.

Software reaches the block over a byte-wide register bus with an address, a read strobe and a write strobe. It owns the enable register and the identification register. It also decodes strobes aimed at the data, line-status and modem-status addresses, because those accesses clear causes. A single interrupt line leaves the block. The line is registered, and it is gated by the auxiliary modem-control output that routes the interrupt onto the system bus.

Top module: `uart_irq_ident`

## Requirements
- R1: The enable register sits at address 1. A write stores bus bits 3:0, where bit 0 enables received data, bit 1 enables transmitter empty, bit 2 enables line status and bit 3 enables modem status. A read at address 1 returns those four bits, with bits 7:4 reading as zero.
- R2: A read at address 2 returns the identification byte. Its bit 0 is 1 when no cause is both latched and enabled, and 0 otherwise. Its bits 7:3 are always zero. A read at any address other than 1 or 2 returns zero on the bus.
- R3: Identification bits 2:1 name the highest-ranked cause that is both latched and enabled. The codes are 11 for line status (top rank), 10 for received data, 01 for transmitter empty and 00 for modem status (bottom rank). The bits read 00 when nothing is latched and enabled.
- R4: The irq output is a register. Its value after each clock edge equals the inverse of identification bit 0 before that edge, ANDed with the out2_en input.
- R5: A read at address 5 clears a latched line-status cause. A read at address 6 clears a latched modem-status cause.
- R6: A read at address 0 clears a latched received-data cause.
- R7: A write at address 0 clears a latched transmitter-empty cause. A read at address 2 also clears it, but only when the identification byte being read reports code 01 with bit 0 low. Otherwise the identification read leaves it latched.
- R8: Clearing an enable bit removes that cause from the identification byte from the next cycle on, and the latched cause is kept. Setting the enable bit again brings the cause back.
- R9: An event pulse in the same cycle as a clearing access leaves that cause latched.
- R10: The clear outputs clr_line, clr_rx, clr_tx and clr_modem are high, in the same cycle, exactly during the accesses that R5, R6 and R7 define for the matching cause.
- R11: While rst_n is low at a clock edge, all enables and latched causes are cleared and irq is cleared, so identification reads 8'h01 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |
| ev_rx_ready | input | 1 | Pulse: a received byte is ready |
| ev_tx_empty | input | 1 | Pulse: transmit holding register became empty |
| ev_line_err | input | 1 | Pulse: line error or break seen |
| ev_modem_chg | input | 1 | Pulse: a modem input changed |
| out2_en | input | 1 | Modem-control output that gates the interrupt line |
| clr_rx | output | 1 | Received-data cause serviced |
| clr_tx | output | 1 | Transmitter-empty cause serviced |
| clr_line | output | 1 | Line-status cause serviced |
| clr_modem | output | 1 | Modem-status cause serviced |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that a bus cycle never raises the read and write strobes together, since a single access path cannot do both. They also assume that rst_n is held for at least one clock edge. The random stimulus draws one access kind per cycle from an exclusive choice, so at most one strobe is ever active. Event pulses and the out2_en gate are drawn freely, which allows events to meet clearing accesses in the same cycle. Directed sequences cover the rank order, masking while a cause is latched, and the identification read that clears only the transmitter cause.

// File: rtl/uart_irq_pkg.sv
// Package: shared constants for the UART interrupt prioritizer.
// Assumes: cause index equals its enable register bit position.
package uart_irq_pkg;
    localparam int unsigned NSRC   = 4;
    localparam int unsigned CODE_W = 2;

    // Cause indices (match enable register bit positions)
    localparam int unsigned SRC_RX = 0;
    localparam int unsigned SRC_TX = 1;
    localparam int unsigned SRC_LS = 2;
    localparam int unsigned SRC_MS = 3;

    // Register addresses
    localparam int unsigned A_DATA = 0;
    localparam int unsigned A_EN   = 1;
    localparam int unsigned A_ID   = 2;
    localparam int unsigned A_LS   = 5;
    localparam int unsigned A_MS   = 6;

    // Identification codes, larger means more urgent
    localparam logic [CODE_W-1:0] CODE_LS = 2'b11;
    localparam logic [CODE_W-1:0] CODE_RX = 2'b10;
    localparam logic [CODE_W-1:0] CODE_TX = 2'b01;
    localparam logic [CODE_W-1:0] CODE_MS = 2'b00;

    // Returns the identification code of a cause index.
    function automatic logic [CODE_W-1:0] code_of(input int unsigned src);
        case (src)
            SRC_LS:  return CODE_LS;
            SRC_RX:  return CODE_RX;
            SRC_TX:  return CODE_TX;
            default: return CODE_MS;
        endcase
    endfunction
endpackage

// File: rtl/uart_irq_en_reg.sv
// Module: interrupt enable register.
// Holds one enable bit per cause. Only the low NSRC bits of a write are stored.
// Assumes: wr is a single-cycle strobe already decoded to this address.
module uart_irq_en_reg #(
    parameter int unsigned NSRC   = 4,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [NSRC-1:0]   en
);
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata[DATA_W-1:NSRC];

    // Store the enable bits on a write, clear them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  en <= '0;
        else if (wr) en <= wdata[NSRC-1:0];
    end
endmodule

// File: rtl/uart_irq_pend.sv
// Module: sticky pending bits, one per cause.
// A set pulse latches the bit and a clear pulse drops it. Set wins a tie.
// Assumes: set and clr are single-cycle pulses.
module uart_irq_pend #(
    parameter int unsigned NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set,
    input  logic [NSRC-1:0] clr,
    output logic [NSRC-1:0] pend
);
    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        // Latch cause i, giving a new event precedence over a service clear.
        always_ff @(posedge clk) begin
            if (!rst_n)      pend[i] <= 1'b0;
            else if (set[i]) pend[i] <= 1'b1;
            else if (clr[i]) pend[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_irq_prio.sv
// Module: fixed-rank priority encoder for the active causes.
// Ranks, from the top: line status, received data, transmitter empty, modem status.
// Assumes: act is already masked by the enables.
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic [NSRC-1:0]   act,
    output logic              none,
    output logic [CODE_W-1:0] code
);
    localparam int unsigned RANK_LOW_FIRST [NSRC] = '{SRC_MS, SRC_TX, SRC_RX, SRC_LS};

    // Walk the causes from lowest to highest rank so the top-ranked active one wins.
    always_comb begin
        code = CODE_MS;
        for (int unsigned k = 0; k < NSRC; k++) begin
            if (act[RANK_LOW_FIRST[k]]) code = code_of(RANK_LOW_FIRST[k]);
        end
        none = (act == '0);
    end
endmodule

// File: rtl/uart_irq_ident.sv
// Module: UART interrupt source prioritizer (top).
// Latches four causes, masks them with the enable register, reports the top
// cause in the identification byte, clears causes on their service accesses and
// drives a registered interrupt line gated by out2_en.
// Assumes: bus_rd and bus_wr are never high together.
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ev_rx_ready,
    input  logic              ev_tx_empty,
    input  logic              ev_line_err,
    input  logic              ev_modem_chg,
    input  logic              out2_en,
    output logic              clr_rx,
    output logic              clr_tx,
    output logic              clr_line,
    output logic              clr_modem,
    output logic              irq
);
    localparam int unsigned ID_PAD = DATA_W - CODE_W - 1;
    localparam int unsigned EN_PAD = DATA_W - NSRC;

    logic [NSRC-1:0]   en, pend, act, set_v, clr_v;
    logic              none;
    logic [CODE_W-1:0] code;
    logic              rd_data, wr_data, wr_en, rd_id, rd_en, rd_ls, rd_ms;

    // Decode the bus strobes per address.
    always_comb begin
        rd_data = bus_rd && (bus_addr == ADDR_W'(A_DATA));
        wr_data = bus_wr && (bus_addr == ADDR_W'(A_DATA));
        wr_en   = bus_wr && (bus_addr == ADDR_W'(A_EN));
        rd_en   = bus_rd && (bus_addr == ADDR_W'(A_EN));
        rd_id   = bus_rd && (bus_addr == ADDR_W'(A_ID));
        rd_ls   = bus_rd && (bus_addr == ADDR_W'(A_LS));
        rd_ms   = bus_rd && (bus_addr == ADDR_W'(A_MS));
    end

    // Gather the events and the service clears into per-cause vectors.
    always_comb begin
        set_v         = '0;
        set_v[SRC_RX] = ev_rx_ready;
        set_v[SRC_TX] = ev_tx_empty;
        set_v[SRC_LS] = ev_line_err;
        set_v[SRC_MS] = ev_modem_chg;
        clr_v         = '0;
        clr_v[SRC_RX] = rd_data;
        clr_v[SRC_TX] = wr_data || (rd_id && !none && (code == CODE_TX));
        clr_v[SRC_LS] = rd_ls;
        clr_v[SRC_MS] = rd_ms;
    end

    assign clr_rx    = clr_v[SRC_RX];
    assign clr_tx    = clr_v[SRC_TX];
    assign clr_line  = clr_v[SRC_LS];
    assign clr_modem = clr_v[SRC_MS];

    uart_irq_en_reg #(.NSRC(NSRC), .DATA_W(DATA_W)) u_en (
        .clk(clk), .rst_n(rst_n), .wr(wr_en), .wdata(bus_wdata), .en(en)
    );

    uart_irq_pend #(.NSRC(NSRC)) u_pend (
        .clk(clk), .rst_n(rst_n), .set(set_v), .clr(clr_v), .pend(pend)
    );

    assign act = pend & en;

    uart_irq_prio u_prio (
        .act(act), .none(none), .code(code)
    );

    // Return the enable or identification byte on a read, zero elsewhere.
    always_comb begin
        if (rd_id)      bus_rdata = {{ID_PAD{1'b0}}, code, none};
        else if (rd_en) bus_rdata = {{EN_PAD{1'b0}}, en};
        else            bus_rdata = '0;
    end

    // Register the gated interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= out2_en && !none;
    end
endmodule

// File: rtl/uart_irq_ident_chk.sv
// Module: property checker for uart_irq_ident, attached by bind.
// Assumes: bus_rd and bus_wr are exclusive.
module uart_irq_ident_chk #(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              out2_en,
    input logic              clr_rx,
    input logic              clr_tx,
    input logic              clr_line,
    input logic              clr_modem,
    input logic              irq
);
    assert_en_hi_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(1)) |-> (bus_rdata[DATA_W-1:4] == '0));
    assert_id_hi_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(2)) |-> (bus_rdata[DATA_W-1:3] == '0));
    assert_irq_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !out2_en |=> !irq);
    assert_clr_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(5)) |-> clr_line);
    assert_clr_modem_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(6)) |-> clr_modem);
    assert_clr_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(0)) |-> clr_rx);
    assert_clr_tx_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(0)) |-> clr_tx);
    assert_clr_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd && !bus_wr) |-> !(clr_rx || clr_tx || clr_line || clr_modem));
endmodule

bind uart_irq_ident uart_irq_ident_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_rdata(bus_rdata), .out2_en(out2_en), .clr_rx(clr_rx), .clr_tx(clr_tx),
    .clr_line(clr_line), .clr_modem(clr_modem), .irq(irq)
);

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ev_rx_ready = 0, ev_tx_empty = 0, ev_line_err = 0, ev_modem_chg = 0;
    logic       out2_en = 1'b0;
    logic       clr_rx, clr_tx, clr_line, clr_modem, irq;

    int n_chk = 0, n_bad = 0;
    logic [3:0] m_en = '0, m_pend = '0;   // bit0 rx, bit1 tx, bit2 line, bit3 modem
    logic       m_irq = 1'b0;
    logic [7:0] last_rd;

    always #2 clk = ~clk;

    uart_irq_ident u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_rx_ready(ev_rx_ready),
        .ev_tx_empty(ev_tx_empty), .ev_line_err(ev_line_err), .ev_modem_chg(ev_modem_chg),
        .out2_en(out2_en), .clr_rx(clr_rx), .clr_tx(clr_tx), .clr_line(clr_line),
        .clr_modem(clr_modem), .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Identification byte from the model, ranks per R3.
    function automatic logic [7:0] id_byte(input logic [3:0] a);
        if (a[2]) return 8'h06;
        if (a[0]) return 8'h04;
        if (a[1]) return 8'h02;
        if (a[3]) return 8'h00;
        return 8'h01;
    endfunction

    // One bus cycle: drive, check same-cycle outputs, step the model, check irq.
    task automatic step(input logic rd, input logic wr, input logic [2:0] a,
                        input logic [7:0] wd, input logic [3:0] ev, input logic g);
        logic [3:0] clrv;
        logic [7:0] idb;
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        ev_rx_ready = ev[0]; ev_tx_empty = ev[1]; ev_line_err = ev[2]; ev_modem_chg = ev[3];
        out2_en = g;
        #1;
        idb = id_byte(m_pend & m_en);
        clrv[0] = rd && a == 3'd0;
        clrv[1] = (wr && a == 3'd0) || (rd && a == 3'd2 && idb == 8'h02);
        clrv[2] = rd && a == 3'd5;
        clrv[3] = rd && a == 3'd6;
        check("R10 clear pulses", {4'b0, clr_modem, clr_line, clr_tx, clr_rx}, {4'b0, clrv});
        if (rd) begin
            last_rd = bus_rdata;
            if (a == 3'd1)      check("R1 enable readback", bus_rdata, {4'b0, m_en});
            else if (a == 3'd2) check("R3 identification", bus_rdata, idb);
            else                check("R2 other address reads zero", bus_rdata, 8'h00);
        end
        m_irq  = g && (idb != 8'h01);
        m_pend = (m_pend & ~clrv) | ev;
        if (wr && a == 3'd1) m_en = wd[3:0];
        @(posedge clk); #1;
        check("R4 irq", {7'b0, irq}, {7'b0, m_irq});
        bus_rd = 0; bus_wr = 0; ev_rx_ready = 0; ev_tx_empty = 0; ev_line_err = 0; ev_modem_chg = 0;
    endtask

    task automatic rd_id(input string tag, input logic [7:0] exp);
        step(1, 0, 3'd2, 8'h00, 4'b0, out2_en);
        check(tag, last_rd, exp);
    endtask

    task automatic ev(input logic [3:0] e);
        step(0, 0, 3'd0, 8'h00, e, out2_en);
    endtask

    initial begin
        #40000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R11 reset state
        #1 check("R11 irq after reset", {7'b0, irq}, 8'h00);
        rd_id("R11 identification after reset", 8'h01);
        step(1, 0, 3'd1, 0, 4'b0, 0); check("R11 enables after reset", last_rd, 8'h00);
        // R1 upper bits dropped
        step(0, 1, 3'd1, 8'hFF, 4'b0, 0);
        step(1, 0, 3'd1, 0, 4'b0, 0); check("R1 enable upper zero", last_rd, 8'h0F);
        // R3 ranking, built up from the bottom
        ev(4'b0010); rd_id("R3 tx code", 8'h02);     // read clears tx (R7)
        rd_id("R7 id read cleared tx", 8'h01);
        ev(4'b1010); rd_id("R3 tx over modem", 8'h02);
        ev(4'b0011); ev(4'b0000);
        rd_id("R3 rx over tx", 8'h04);
        ev(4'b0100); rd_id("R3 line top", 8'h06);
        rd_id("R7 id read keeps tx when line reported", 8'h06);
        step(1, 0, 3'd5, 0, 4'b0, 0); rd_id("R5 lsr read clears line", 8'h04);
        step(1, 0, 3'd0, 0, 4'b0, 0); rd_id("R6 data read clears rx", 8'h02);
        step(0, 1, 3'd0, 8'h55, 4'b0, 0); rd_id("R7 data write clears tx", 8'h00);
        step(1, 0, 3'd6, 0, 4'b0, 0); rd_id("R5 msr read clears modem", 8'h01);
        // R8 masking keeps the latched cause
        ev(4'b0010);
        step(0, 1, 3'd1, 8'h00, 4'b0, 0); rd_id("R8 masked tx hidden", 8'h01);
        step(0, 1, 3'd1, 8'h02, 4'b0, 0); rd_id("R8 unmasked tx returns", 8'h02);
        // R9 event beats a same-cycle clear
        step(0, 1, 3'd1, 8'h0F, 4'b0, 0);
        step(1, 0, 3'd5, 0, 4'b0100, 0); rd_id("R9 line kept on tie", 8'h06);
        // R4 gating
        step(0, 0, 3'd0, 0, 4'b0, 1); step(0, 0, 3'd0, 0, 4'b0, 1);
        check("R4 irq gated on", {7'b0, irq}, 8'h01);
        step(0, 0, 3'd0, 0, 4'b0, 0);
        check("R4 irq gated off", {7'b0, irq}, 8'h00);
        // Random traffic, one access kind per cycle
        for (int i = 0; i < 3000; i++) begin
            int unsigned kind = $urandom_range(0, 3);
            logic [2:0] a = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 3) == 0) a = 3'd2;
            step(kind == 1, kind == 2, a, 8'($urandom), 4'($urandom) & 4'($urandom),
                 1'($urandom_range(0, 3) != 0));
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule